// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol engine of a 256-byte serial memory that sits on a two-wire bus as a slave. It watches the clock and data lines through a synchronizer, recognises start and stop conditions, and shifts in a control byte, a word address and data bytes. It acknowledges by pulling the data line low through an open-drain enable, and it drives read data from the same enable. Outgoing changes are held back a fixed number of system clocks after the clock line is seen falling, so the engine never moves the data line near a clock edge.

A single word pointer serves both directions and survives from one transaction to the next. A write transaction loads it from the word address; every data byte that follows is handed to an external page-write controller as one beat on a valid/ready channel, and a stop after at least one beat gives a one-cycle commit pulse. The memory array is read through a plain lookup port: the engine presents the pointer on `rd_addr` and expects `rd_data` to hold that byte in the same cycle. While the page-write controller reports busy, the engine acknowledges nothing, so a bus master can poll for the end of a write cycle.

The write channel follows valid/ready rules: `wr_valid` rises with `wr_addr` and `wr_data`, and all three hold still until a cycle in which `wr_ready` is high. The controller may hold `wr_ready` low for as long as it likes; the engine pushes back on the bus by refusing the next data byte.

Top module: `serial_mem_slave`

## Requirements
- R1: A falling data line while the synchronized clock is high is a start, a rising one is a stop; data bits are taken only on rising clock edges, and a stop in the middle of a byte returns the engine to idle, where it acknowledges nothing and forwards nothing until the next start.
- R2: The first byte after a start is the control byte, sent MSB first; it is acknowledged when its bits 7..4 equal 1010 (bits 3..1 are ignored), and its bit 0 selects a read (1) or a write (0).
- R3: A control byte whose bits 7..4 differ from 1010 is not acknowledged, and the engine stays silent on every later byte until the next start.
- R4: In a write, the byte after the control byte is loaded into the pointer; each further byte is acknowledged and issued as one beat carrying the pointer as address, after which the pointer advances by one modulo 256.
- R5: A read returns the byte at the pointer, MSB first, and the pointer then advances by one, so a current-address read following an access to address n returns the byte at n+1.
- R6: A repeated start after the word address keeps the loaded pointer for a following read and produces no commit pulse.
- R7: A stop that ends a write in which at least one beat was issued produces exactly one one-cycle `wr_commit` pulse; any other stop produces none.
- R8: While `busy_i` is high when a byte completes, that byte (control, address or data) is not acknowledged.
- R9: During a read, a master acknowledge makes the engine send the next byte, the pointer wrapping from 0xFF to 0x00; a missing acknowledge makes it release the data line and wait for a start or stop.
- R10: A beat holds `wr_valid`, `wr_addr` and `wr_data` steady until accepted; a data byte that completes while the previous beat is still unaccepted is not acknowledged, not forwarded, and leaves the pointer unchanged.
- R11: A start at any point aborts the transfer in progress and the next byte is treated as a control byte.
- R12: `sda_oe` changes only a fixed SYNC_STAGES+1+HOLD_CYC system clocks after the clock line falls, and never asserts while the synchronized clock is high.
- R13: After reset `sda_oe`, `wr_valid` and `wr_commit` are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| busy_i | input | 1 | Page-write controller is in a write cycle |
| rd_addr | output | ADDR_W | Pointer presented to the memory array |
| rd_data | input | 8 | Array byte at `rd_addr`, same cycle |
| wr_valid | output | 1 | A write beat is offered |
| wr_ready | input | 1 | The controller takes the beat this cycle |
| wr_addr | output | ADDR_W | Address of the offered beat |
| wr_data | output | 8 | Data of the offered beat |
| wr_commit | output | 1 | One-cycle pulse: start the write cycle |

## Verification
Every bus edge reaches the engine SYNC_STAGES+1 system clocks after the pad moves, so a beat appears that long after the eighth rising clock of a data byte and a commit pulse that long after the data line rises for a stop; `sda_oe` moves SYNC_STAGES+1+HOLD_CYC clocks after a falling bus clock. The bench drives the bus on falling system-clock edges and samples the data line in the middle of the bus-clock high phase, long after that latency has elapsed, while the output-hold check reads `sda_oe` exactly one clock before and on the cycle the change is due. Beat and commit counts are read only after a full bus phase has passed.

// File: rtl/sms_pkg.sv
package sms_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA
  } phase_e;

  typedef struct packed {
    logic scl;
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_evt_t;
endpackage

// File: rtl/sms_bus_sync.sv
module sms_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output sms_pkg::bus_evt_t evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_p, sda_p;
  logic              scl_s, sda_s;

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_comb begin
    evt.scl      = scl_s;
    evt.sda      = sda_s;
    evt.scl_rise = scl_s & ~scl_p;
    evt.scl_fall = ~scl_s & scl_p;
    evt.start    = scl_s & scl_p & sda_p & ~sda_s;
    evt.stop     = scl_s & scl_p & ~sda_p & sda_s;
  end
endmodule

// File: rtl/sms_sda_drive.sv
module sms_sda_drive #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  input  logic nxt_low,
  input  logic rel_now,
  input  logic scl_hi,
  output logic oe
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;
  logic          pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
      oe   <= 1'b0;
    end else if (rel_now) begin
      cnt  <= '0;
      pend <= 1'b0;
      oe   <= 1'b0;
    end else if (fall) begin
      cnt  <= CW'(HOLD);
      pend <= nxt_low;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) oe <= pend;
    end
  end

  // R12: the line is never pulled low while the clock is high
  a_r12_pull_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> !scl_hi);

  // R12: no change in the cycle right after a falling clock
  a_r12_hold_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall && !rel_now |=> $stable(oe));
endmodule

// File: rtl/sms_byte_engine.sv
module sms_byte_engine #(
  parameter int          ADDR_W   = 8,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sms_pkg::bus_evt_t evt,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic              nxt_low,
  output logic              rel_now
);
  import sms_pkg::*;

  phase_e            ph;
  logic [2:0]        bitc;
  logic [6:0]        sh;
  logic [7:0]        tx;
  logic              ack_slot, ack_me, rd_sel, got_data;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        byte_in;
  logic              rx_ph, take, last_bit;

  assign byte_in  = {sh, evt.sda};
  assign rx_ph    = (ph == PH_CTRL) || (ph == PH_ADDR) || (ph == PH_WDATA);
  assign take     = wr_valid & wr_ready;
  assign last_bit = (bitc == 3'd7);
  assign rd_addr  = ptr;
  assign rel_now  = evt.start | evt.stop;

  always_comb begin
    nxt_low = 1'b0;
    if (ack_slot && rx_ph) nxt_low = ack_me;
    else if (!ack_slot && ph == PH_RDATA) nxt_low = ~tx[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      bitc      <= '0;
      sh        <= '0;
      tx        <= '1;
      ack_slot  <= 1'b0;
      ack_me    <= 1'b0;
      rd_sel    <= 1'b0;
      got_data  <= 1'b0;
      ptr       <= '0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      wr_commit <= 1'b0;
      if (take) wr_valid <= 1'b0;
      if (evt.start) begin
        ph       <= PH_CTRL;
        bitc     <= '0;
        ack_slot <= 1'b0;
        ack_me   <= 1'b0;
        got_data <= 1'b0;
      end else if (evt.stop) begin
        ph        <= PH_IDLE;
        ack_slot  <= 1'b0;
        ack_me    <= 1'b0;
        wr_commit <= got_data;
        got_data  <= 1'b0;
      end else if (evt.scl_rise && ph != PH_IDLE) begin
        if (!ack_slot) begin
          bitc <= bitc + 1'b1;
          sh   <= byte_in[6:0];
          if (ph == PH_RDATA) tx <= {tx[6:0], 1'b1};
          if (last_bit) begin
            ack_slot <= 1'b1;
            if (ph == PH_CTRL) begin
              ack_me <= (byte_in[7:4] == DEV_CODE) && !busy_i;
              rd_sel <= byte_in[0];
            end else if (ph == PH_ADDR) begin
              ack_me <= !busy_i;
              if (!busy_i) ptr <= byte_in[ADDR_W-1:0];
            end else if (ph == PH_WDATA) begin
              if (!busy_i && (!wr_valid || take)) begin
                ack_me   <= 1'b1;
                wr_valid <= 1'b1;
                wr_addr  <= ptr;
                wr_data  <= byte_in;
                ptr      <= ptr + 1'b1;
                got_data <= 1'b1;
              end else begin
                ack_me <= 1'b0;
              end
            end
          end
        end else begin
          ack_slot <= 1'b0;
          ack_me   <= 1'b0;
          bitc     <= '0;
          if (ph == PH_RDATA) begin
            if (!evt.sda) begin
              tx  <= rd_data;
              ptr <= ptr + 1'b1;
            end else begin
              ph <= PH_IDLE;
            end
          end else if (!ack_me) begin
            ph <= PH_IDLE;
          end else if (ph == PH_CTRL) begin
            if (rd_sel) begin
              ph  <= PH_RDATA;
              tx  <= rd_data;
              ptr <= ptr + 1'b1;
            end else begin
              ph <= PH_ADDR;
            end
          end else if (ph == PH_ADDR) begin
            ph <= PH_WDATA;
          end
        end
      end
    end
  end

  // R3: a foreign device code is never acknowledged
  a_r3_foreign_code_nack: assert property (@(posedge clk) disable iff (!rst_n)
    evt.scl_rise && ph == PH_CTRL && !ack_slot && last_bit &&
    byte_in[7:4] != DEV_CODE |=> !ack_me);

  // R8: a byte completed while busy is not acknowledged
  a_r8_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_slot) && ph != PH_RDATA && $past(busy_i) |-> !ack_me);

  // R10: an offered beat holds until it is taken
  a_r10_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_addr));

  // R7: commit is a single-cycle pulse backed by a forwarded beat
  a_r7_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(got_data) && !got_data);
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         HOLD_CYC    = 4,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit
);
  sms_pkg::bus_evt_t evt;
  logic              nxt_low, rel_now;

  sms_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt   (evt)
  );

  sms_byte_engine #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .busy_i    (busy_i),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_commit (wr_commit),
    .nxt_low   (nxt_low),
    .rel_now   (rel_now)
  );

  sms_sda_drive #(.HOLD(HOLD_CYC)) u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .fall    (evt.scl_fall),
    .nxt_low (nxt_low),
    .rel_now (rel_now),
    .scl_hi  (evt.scl),
    .oe      (sda_oe)
  );
endmodule

// File: tb/serial_mem_slave_tb.sv
`timescale 1ns/1ps
module serial_mem_slave_tb;
  localparam int SYNC = 2;
  localparam int HOLD = 4;
  localparam int LAT  = SYNC + 1 + HOLD;
  localparam int Q    = 10;
  localparam int BUSY_CYC = 400;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, scl_m, sda_m, ready_en;
  logic sda_oe, sda_bus, wr_valid, wr_commit, busy_i;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;

  assign sda_bus = sda_m & ~sda_oe;

  serial_mem_slave #(.ADDR_W(8), .SYNC_STAGES(SYNC), .HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .busy_i(busy_i), .rd_addr(rd_addr), .rd_data(rd_data), .wr_valid(wr_valid),
    .wr_ready(ready_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
  );

  // page-write controller and array model
  logic [7:0] mem [0:255];
  logic [7:0] cap_a [0:1023];
  logic [7:0] cap_d [0:1023];
  int cap_n = 0, applied = 0, commit_n = 0, busy_cnt = 0;

  function automatic logic [7:0] init_byte(input int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = init_byte(i);
      cap_n = 0; applied = 0; commit_n = 0; busy_cnt = 0;
    end else begin
      if (busy_cnt != 0) busy_cnt = busy_cnt - 1;
      if (wr_valid && ready_en) begin
        cap_a[cap_n] = wr_addr; cap_d[cap_n] = wr_data; cap_n = cap_n + 1;
      end
      if (wr_commit) begin
        for (int i = applied; i < cap_n; i++) mem[cap_a[i]] = cap_d[i];
        applied = cap_n; commit_n = commit_n + 1; busy_cnt = BUSY_CYC;
      end
    end
  end
  assign busy_i  = (busy_cnt != 0);
  assign rd_data = mem[rd_addr];

  int checks = 0, fails = 0;
  bit done = 0;
  logic g_pre, g_post, t_pre, t_post;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    sda_m = b; half(Q);
    scl_m = 1'b1; half(Q);
    s = sda_bus; half(Q);
    scl_m = 1'b0;
    half(LAT - 1); g_pre = sda_oe;
    half(1); g_post = sda_oe;
    half(Q - LAT);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; half(Q); scl_m = 1'b1; half(Q);
    sda_m = 1'b0; half(Q); scl_m = 1'b0; half(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; half(Q); scl_m = 1'b1; half(Q); sda_m = 1'b1; half(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    t_pre = g_pre; t_post = g_post;
    clock_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] v);
    logic s;
    v = '0;
    for (int i = 0; i < 8; i++) begin clock_bit(1'b1, s); v = {v[6:0], s}; end
    clock_bit(mack ? 1'b0 : 1'b1, s);
  endtask

  task automatic wait_ready();
    logic ack;
    int tries = 0;
    do begin
      bus_start(); send_byte(8'hA0, ack); tries++;
    end while (!ack && tries < 20);
    chk(ack, "R8 poll eventually acked", ack, 1);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack, a2;
    logic [7:0] v;
    int base, cb;
    void'($urandom(32'h5EED_0C1A));
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; ready_en = 1'b1;
    half(5); rst_n = 1'b1; half(2);

    // R13 reset state
    chk(sda_oe == 0 && wr_valid == 0 && wr_commit == 0, "R13 outputs idle", {sda_oe, wr_valid, wr_commit}, 0);
    chk(rd_addr == 0, "R13 pointer zero", rd_addr, 0);

    // R2 block bits ignored, R12 drive latency, R4 byte/page write, R7 commit
    base = cap_n; cb = commit_n;
    bus_start(); send_byte(8'hAE, ack);
    chk(ack, "R2 control with block bits set", ack, 1);
    chk(t_pre == 0 && t_post == 1, "R12 ack appears exactly LAT clocks after fall", {t_pre, t_post}, 2'b01);
    send_byte(8'h10, ack); chk(ack, "R4 address acked", ack, 1);
    send_byte(8'h5A, ack); chk(ack, "R4 data acked", ack, 1);
    send_byte(8'hC3, ack); chk(ack, "R4 data acked", ack, 1);
    bus_stop();
    chk(cap_n == base + 2, "R4 beat count", cap_n - base, 2);
    chk(cap_a[base] == 8'h10 && cap_d[base] == 8'h5A, "R4 first beat", {cap_a[base], cap_d[base]}, 16'h105A);
    chk(cap_a[base+1] == 8'h11 && cap_d[base+1] == 8'hC3, "R4 second beat", {cap_a[base+1], cap_d[base+1]}, 16'h11C3);
    chk(commit_n == cb + 1, "R7 one commit", commit_n - cb, 1);

    // R8 polling right after the stop is refused
    bus_start(); send_byte(8'hA0, ack);
    chk(!ack, "R8 control nacked while busy", ack, 0);
    wait_ready();

    // R5 random read, R6 no commit on repeated start
    cb = commit_n;
    bus_start(); send_byte(8'hA0, ack); send_byte(8'h10, ack);
    bus_start(); send_byte(8'hA1, ack); chk(ack, "R2 read control acked", ack, 1);
    read_byte(1'b0, v); bus_stop();
    chk(v == 8'h5A, "R5 random read", v, 8'h5A);
    chk(commit_n == cb, "R6 no commit after address-only write", commit_n - cb, 0);

    // R5 current-address read
    bus_start(); send_byte(8'hA1, ack); read_byte(1'b0, v); bus_stop();
    chk(v == 8'hC3, "R5 current-address read", v, 8'hC3);
    chk(sda_oe == 0, "R9 released after master nack", sda_oe, 0);

    // R9 sequential read across the top of the array
    bus_start(); send_byte(8'hA0, ack); send_byte(8'hFE, ack);
    bus_start(); send_byte(8'hA1, ack);
    read_byte(1'b1, v); chk(v == mem[8'hFE], "R9 seq byte 0", v, mem[8'hFE]);
    read_byte(1'b1, v); chk(v == mem[8'hFF], "R9 seq byte 1", v, mem[8'hFF]);
    read_byte(1'b0, v); chk(v == mem[8'h00], "R9 seq wrap to 00", v, mem[8'h00]);
    bus_stop();
    bus_start(); send_byte(8'hA1, ack); read_byte(1'b0, v); bus_stop();
    chk(v == mem[8'h01], "R9 pointer after wrap", v, mem[8'h01]);

    // R3 foreign device code
    base = cap_n; cb = commit_n;
    bus_start(); send_byte(8'h50, ack); chk(!ack, "R3 foreign code nacked", ack, 0);
    send_byte(8'hA0, ack); chk(!ack, "R3 silent until next start", ack, 0);
    bus_stop();
    chk(cap_n == base && commit_n == cb, "R3 nothing forwarded", cap_n - base, 0);

    // R1 stop in the middle of a data byte
    bus_start(); send_byte(8'hA0, ack); send_byte(8'h20, ack);
    for (int i = 0; i < 4; i++) clock_bit(1'b1, a2);
    bus_stop();
    send_byte(8'hA0, ack); chk(!ack, "R1 idle after mid-byte stop", ack, 0);
    bus_stop();
    chk(cap_n == base && commit_n == cb, "R1 no beat or commit", commit_n - cb, 0);

    // R11 start aborts a byte in progress
    bus_start(); send_byte(8'hA0, ack); send_byte(8'h40, ack);
    for (int i = 0; i < 3; i++) clock_bit(1'b0, a2);
    bus_start(); send_byte(8'hA1, ack);
    chk(ack, "R11 control after abort acked", ack, 1);
    read_byte(1'b0, v); bus_stop();
    chk(v == mem[8'h40], "R11 read after abort", v, mem[8'h40]);
    chk(cap_n == base && commit_n == cb, "R11 aborted byte not forwarded", cap_n - base, 0);

    // R10 back-pressure
    ready_en = 1'b0;
    bus_start(); send_byte(8'hA0, ack); send_byte(8'h30, ack);
    send_byte(8'h11, ack); chk(ack, "R10 first pending byte acked", ack, 1);
    send_byte(8'h22, ack); chk(!ack, "R10 byte behind pending beat nacked", ack, 0);
    chk(wr_valid && wr_addr == 8'h30 && wr_data == 8'h11, "R10 beat held", {wr_valid, wr_addr, wr_data}, 17'h13011);
    chk(cap_n == base, "R10 nothing taken while not ready", cap_n - base, 0);
    ready_en = 1'b1; half(2);
    chk(cap_n == base + 1 && cap_d[base] == 8'h11, "R10 beat taken once", cap_n - base, 1);
    bus_stop();
    chk(commit_n == cb + 1, "R7 commit after partial write", commit_n - cb, 1);
    wait_ready();
    bus_start(); send_byte(8'hA0, ack); send_byte(8'h30, ack);
    bus_start(); send_byte(8'hA1, ack);
    read_byte(1'b1, v); chk(v == 8'h11, "R10 stored byte", v, 8'h11);
    read_byte(1'b0, v); chk(v == init_byte(8'h31), "R10 refused byte not stored", v, init_byte(8'h31));
    bus_stop();

    // random writes then read-back
    for (int it = 0; it < 12; it++) begin
      logic [7:0] ad;
      logic [7:0] dat [0:3];
      int n;
      ad = 8'($urandom % 256);
      n = 1 + int'($urandom % 4);
      base = cap_n; cb = commit_n;
      bus_start(); send_byte({4'hA, 3'($urandom), 1'b0}, ack);
      chk(ack, "R2 random block bits", ack, 1);
      send_byte(ad, ack);
      for (int k = 0; k < n; k++) begin
        dat[k] = 8'($urandom);
        send_byte(dat[k], ack); chk(ack, "R4 random data acked", ack, 1);
      end
      bus_stop();
      for (int k = 0; k < n; k++)
        chk(cap_a[base+k] == 8'(ad + k) && cap_d[base+k] == dat[k], "R4 random beat",
            {cap_a[base+k], cap_d[base+k]}, {8'(ad + k), dat[k]});
      chk(commit_n == cb + 1, "R7 random commit", commit_n - cb, 1);
      wait_ready();
      bus_start(); send_byte(8'hA0, ack); send_byte(ad, ack);
      bus_start(); send_byte({4'hA, 3'($urandom), 1'b1}, ack);
      for (int k = 0; k < n; k++) begin
        read_byte(k != n - 1, v);
        chk(v == dat[k], "R5 R9 random read-back", v, dat[k]);
      end
      bus_stop();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule